// File: doc/BRIEF.md
# Prescaled Timer/Counter with Buffered High Byte

This block is a register-mapped timer/counter for a small controller. It advances either on a per-cycle tick from the surrounding logic or on edges of an asynchronous external input, which it synchronizes and edge-detects internally. An 8-bit prescaler with a power-of-two divide ratio can sit in front of the count, or be bypassed. Software sets the count to 8 or 16 bits wide. A sticky overflow flag, gated by an enable bit, drives a single interrupt request pin.

Software reaches the block through a synchronous register port. The port is always ready, so it has no back-pressure: a write completes on the clock edge where `wr` is high, and `rdata` always reflects the register that `addr` selects. The live high byte of the count cannot be accessed directly. A read of the low byte copies the live high byte into a buffer in the same cycle, so the 16-bit pair reads consistently. A write of the low byte moves the buffered value into the live high byte, so all 16 bits load together. Writing the low byte also restarts the prescaler and holds off counting for two tick periods.

Top module: `pscnt_timer`

## Requirements
- R1: With control bit 5 (source) at 0, each `tick` cycle is one count event.
- R2: With control bit 5 at 1, the count events are edges of `ext_in` after a two-flop synchronizer. Control bit 4 at 0 selects rising edges and at 1 selects falling edges.
- R3: A write to address 1 loads the low byte from `wdata`. Count events are then discarded during the next two `tick` periods.
- R4: With control bit 3 at 0, the count advances once every 2^(r+1) events, where r is control bits 2:0 (from 1:2 up to 1:256). With bit 3 at 1, it advances on every event.
- R5: A write to address 1 or address 2 clears the prescaler count. The control register keeps its value.
- R6: Control bit 6 selects the width: 1 for 8 bits and 0 for 16 bits. In 8-bit mode the low byte wraps from FFh to 00h, sets the flag, and leaves the high byte untouched. In 16-bit mode only the wrap from FFFFh to 0000h sets the flag.
- R7: The overflow flag (address 3, bit 0) stays set until software writes 0 to it. An overflow in the same cycle as that write wins.
- R8: `irq` is high exactly when the flag and the enable bit (address 3, bit 1) are both 1.
- R9: In 16-bit mode, a read strobe at address 1 copies the live high byte into the buffer at that edge. Address 2 reads the buffer.
- R10: A write to address 2 changes only the buffer. In 16-bit mode, a write to address 1 loads the buffer into the live high byte.
- R11: With control bit 7 (run) at 0, the count does not change except through register writes.
- R12: After reset the control register (address 0) reads FFh, address 3 reads 00h, and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Internal count tick, one cycle per period |
| ext_in | input | 1 | Asynchronous external count input |
| addr | input | 2 | Register select: 0 control, 1 low byte, 2 high buffer, 3 flag/enable |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe (side effect on address 1 only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by `addr` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or terminal count shows up as a low byte that is off by one or more after a known number of ticks. It becomes visible within a single divide period of the first affected event. A stall counter that is wrong moves the whole count by up to two after every low-byte write. A high-byte buffer that is captured or committed at the wrong moment makes the two halves read from different instants, which is visible on the next address-2 read. A flag error shows on `irq` and at address 3 one cycle after the wrapping edge.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 2'd3;

  typedef struct packed {
    logic       run;
    logic       narrow;
    logic       ext_src;
    logic       fall_edge;
    logic       bypass;
    logic [2:0] ratio;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = ctrl_t'(8'hFF);
endpackage

// File: rtl/pscnt_edge_sync.sv
module pscnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_comb begin
    if (fall_sel) pulse = prev_q & ~cur;
    else          pulse = cur & ~prev_q;
  end
endmodule

// File: rtl/pscnt_prescaler.sv
module pscnt_prescaler #(
  parameter int PS_W  = 8,
  localparam int SEL_W = $clog2(PS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev,
  input  logic             bypass,
  input  logic [SEL_W-1:0] ratio,
  output logic             bump,
  output logic [PS_W-1:0]  count
);
  logic [PS_W-1:0]  pcnt_q;
  logic [PS_W-1:0]  pnext;
  logic [PS_W-1:0]  mask;
  logic [SEL_W-1:0] shamt;

  assign shamt = SEL_W'(PS_W - 1) - ratio;
  assign mask  = {PS_W{1'b1}} >> shamt;
  assign pnext = pcnt_q + PS_W'(1);

  always_comb begin
    if (bypass) bump = ev;
    else        bump = ev && ((pnext & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                pcnt_q <= '0;
    else if (clr)              pcnt_q <= '0;
    else if (ev && !bypass)    pcnt_q <= pnext;
  end

  assign count = pcnt_q;
endmodule

// File: rtl/pscnt_stall.sv
module pscnt_stall #(
  parameter int STALL_TICKS = 2,
  localparam int SW = $clog2(STALL_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic hold
);
  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      left_q <= '0;
    else if (load)                   left_q <= SW'(STALL_TICKS);
    else if (tick && left_q != '0)   left_q <= left_q - SW'(1);
  end

  assign hold = (left_q != '0);
endmodule

// File: rtl/pscnt_core.sv
module pscnt_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         narrow,
  input  logic         lo_wr,
  input  logic         hi_wr,
  input  logic         lo_rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic [W-1:0] hbuf,
  output logic         wrap
);
  logic [W-1:0]   lo_q, hi_q, hbuf_q;
  logic [2*W-1:0] wide_next;
  logic [W-1:0]   lo_next;

  assign wide_next = {hi_q, lo_q} + (2*W)'(1);
  assign lo_next   = lo_q + W'(1);

  always_comb begin
    if (narrow) wrap = inc && (lo_q == {W{1'b1}});
    else        wrap = inc && ({hi_q, lo_q} == {(2*W){1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (lo_wr) begin
      lo_q <= wdata;
      if (!narrow) hi_q <= hbuf_q;
    end else if (inc) begin
      if (narrow) begin
        lo_q <= lo_next;
      end else begin
        lo_q <= wide_next[W-1:0];
        hi_q <= wide_next[2*W-1:W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 hbuf_q <= '0;
    else if (hi_wr)             hbuf_q <= wdata;
    else if (lo_rd && !narrow)  hbuf_q <= hi_q;
  end

  assign lo   = lo_q;
  assign hi   = hi_q;
  assign hbuf = hbuf_q;
endmodule

// File: rtl/pscnt_timer.sv
module pscnt_timer
  import pscnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ext_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic              flag_q, ien_q;
  logic              ctrl_wr, lo_wr, hi_wr, irq_wr, lo_rd;
  logic              edge_ev, src_ev, count_ev, hold, bump, wrap;
  logic [DATA_W-1:0] cnt_lo, cnt_hi, hbuf, pre_cnt;

  assign ctrl_wr = wr && (addr == ADDR_CTRL);
  assign lo_wr   = wr && (addr == ADDR_LO);
  assign hi_wr   = wr && (addr == ADDR_HI);
  assign irq_wr  = wr && (addr == ADDR_IRQ);
  assign lo_rd   = rd && (addr == ADDR_LO);

  pscnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in),
    .fall_sel(ctrl_q.fall_edge), .pulse(edge_ev)
  );

  pscnt_stall #(.STALL_TICKS(STALL_TICKS)) u_stall (
    .clk(clk), .rst_n(rst_n), .load(lo_wr), .tick(tick), .hold(hold)
  );

  assign src_ev   = ctrl_q.ext_src ? edge_ev : tick;
  assign count_ev = ctrl_q.run && !hold && !lo_wr && src_ev;

  pscnt_prescaler #(.PS_W(DATA_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(lo_wr || hi_wr), .ev(count_ev),
    .bypass(ctrl_q.bypass), .ratio(ctrl_q.ratio), .bump(bump), .count(pre_cnt)
  );

  pscnt_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(bump), .narrow(ctrl_q.narrow),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .lo_rd(lo_rd), .wdata(wdata),
    .lo(cnt_lo), .hi(cnt_hi), .hbuf(hbuf), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wrap)        flag_q <= 1'b1;
      else if (irq_wr) flag_q <= wdata[0];
      if (irq_wr)      ien_q  <= wdata[1];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdata = ctrl_q;
      ADDR_LO:   rdata = cnt_lo;
      ADDR_HI:   rdata = hbuf;
      default:   rdata = {{(DATA_W-2){1'b0}}, ien_q, flag_q};
    endcase
  end

  assign irq = flag_q & ien_q;
endmodule

// File: rtl/pscnt_timer_chk.sv
module pscnt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr,
  input logic       rd,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic [7:0] hbuf,
  input logic [7:0] pre_cnt,
  input logic       flag_q,
  input logic       ien_q,
  input logic       run,
  input logic       narrow,
  input logic       irq
);
  // R3: counting is held during the first two cycles after a low-byte write
  a_r3_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1) ##1 !wr |=> $stable(cnt_lo));
  a_r3_stall_second: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1) ##1 !wr ##1 !wr |=> $stable(cnt_lo));
  // R5
  a_r5_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == 2'd1 || addr == 2'd2)) |=> (pre_cnt == 8'd0));
  // R6
  a_r6_narrow_hi: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |=> $stable(cnt_hi));
  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr && addr == 2'd3)) |=> flag_q);
  // R8
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq);
  // R9
  a_r9_buf_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd1 && !narrow && !(wr && addr == 2'd2)) |=> (hbuf == $past(cnt_hi)));
  // R11
  a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr && addr == 2'd1)) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

bind pscnt_timer pscnt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .hbuf(hbuf), .pre_cnt(pre_cnt),
  .flag_q(flag_q), .ien_q(ien_q), .run(ctrl_q.run), .narrow(ctrl_q.narrow),
  .irq(irq)
);

// File: tb/pscnt_timer_tb.sv
`timescale 1ns/1ps
module pscnt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext_in = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pscnt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_in(ext_in), .addr(addr),
    .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = ~ext_in;
      repeat (4) @(negedge clk);
      ext_in = ~ext_in;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    bus_rd(2'd0, d); check("R12 ctrl", d, 8'hFF);
    bus_rd(2'd3, d); check("R12 flag/en", d, 8'h00);
    bus_rd(2'd1, d); check("R12 count", d, 8'h00);
    #1 check("R12 irq", irq, 0);

    // R1/R3: internal ticks, 8-bit, bypass
    bus_wr(2'd0, 8'hC8);
    bus_wr(2'd1, 8'h20);
    run_ticks(2);
    bus_rd(2'd1, d); check("R3 stall two ticks", d, 8'h20);
    run_ticks(1);
    bus_rd(2'd1, d); check("R3 count after stall", d, 8'h21);
    bus_wr(2'd1, 8'h10);
    run_ticks(7);
    bus_rd(2'd1, d); check("R1 tick count", d, 8'h15);

    // R4/R5 prescaler ratio sweep
    for (int r = 0; r < 8; r++) begin
      int div;
      div = 1 << (r + 1);
      bus_wr(2'd0, 8'hC0 | 8'(r));
      bus_wr(2'd1, 8'h00);
      run_ticks(2 + 3 * div + (div - 1));
      bus_rd(2'd1, d); check($sformatf("R4 ratio %0d", r), d, 3);
      bus_rd(2'd0, d); check("R5 ctrl kept", d, 8'hC0 | 8'(r));
    end

    // R5 prescaler cleared by timer write (div 8)
    bus_wr(2'd0, 8'hC2);
    bus_wr(2'd1, 8'h00);
    run_ticks(2 + 5);
    bus_wr(2'd1, 8'h00);
    run_ticks(2 + 7);
    bus_rd(2'd1, d); check("R5 prescaler cleared", d, 0);
    bus_wr(2'd2, 8'h00);
    run_ticks(1);
    bus_wr(2'd2, 8'h00);
    run_ticks(7);
    bus_rd(2'd1, d); check("R5 hi write clears", d, 0);

    // R6/R7/R8 8-bit overflow
    bus_wr(2'd0, 8'hC8);
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd1, 8'hFE);
    run_ticks(4);
    bus_rd(2'd1, d); check("R6 8-bit wrap", d, 8'h00);
    bus_rd(2'd3, d); check("R6 flag set", d, 8'h01);
    #1 check("R8 masked irq", irq, 0);
    run_ticks(5);
    bus_rd(2'd3, d); check("R7 flag sticky", d, 8'h01);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, d); check("R7 flag cleared", d, 8'h02);
    #1 check("R8 irq low", irq, 0);
    bus_wr(2'd1, 8'hFF);
    run_ticks(3);
    #1 check("R8 irq high", irq, 1);
    bus_wr(2'd3, 8'h00);
    #1 check("R8 irq cleared", irq, 0);

    // R9/R10 16-bit buffered access
    bus_wr(2'd0, 8'h88);
    bus_wr(2'd2, 8'h12);
    bus_wr(2'd1, 8'h34);
    run_ticks(2 + 16);
    bus_rd(2'd1, d); check("R9 low", d, 8'h44);
    bus_rd(2'd2, d); check("R9 high buffered", d, 8'h12);
    bus_wr(2'd2, 8'h55);
    bus_rd(2'd2, d); check("R10 buffer written", d, 8'h55);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d); check("R10 live high unchanged", d, 8'h12);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd1, 8'hFF);
    run_ticks(3);
    bus_rd(2'd1, d); check("R6 16-bit carry low", d, 8'h00);
    bus_rd(2'd2, d); check("R6 16-bit carry high", d, 8'h01);
    bus_rd(2'd3, d); check("R6 no flag on byte carry", d, 8'h00);
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd1, 8'hFF);
    run_ticks(3);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d); check("R6 16-bit wrap high", d, 8'h00);
    bus_rd(2'd3, d); check("R6 16-bit flag", d, 8'h01);

    // R2 external edges
    bus_wr(2'd0, 8'hE8);
    bus_wr(2'd1, 8'h00);
    run_ticks(2);
    ext_pulses(5);
    bus_rd(2'd1, d); check("R2 rising edges", d, 5);
    bus_wr(2'd0, 8'hF8);
    bus_wr(2'd1, 8'h00);
    run_ticks(2);
    ext_pulses(3);
    bus_rd(2'd1, d); check("R2 falling edges", d, 3);

    // R11 halted
    bus_wr(2'd0, 8'h48);
    bus_wr(2'd1, 8'h07);
    run_ticks(10);
    bus_rd(2'd1, d); check("R11 halted", d, 8'h07);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule